// File: doc/BRIEF.md
# Block-Copy DMA Channel

This block is one DMA channel that moves a block of data from a source region to a destination region. A block is organised as frames, and each frame holds a number of elements. An element is a byte, a halfword or a word. Software sets up the channel through sixteen word-wide registers, picked by `regAddr`, and starts it by setting the enable bit. The engine then works one element at a time. It reads the element from the current source address, writes the same element to the current destination address, and moves both addresses on according to their own modes.

Each side has its own address mode: constant or post-increment. Post-increment moves the address by a stride. The stride is built from the element size and a signed index register, with one index used inside a frame and a second index used when a frame ends. The current addresses and the progress counters can be read back at any time. When the last element has been written, the engine clears the enable bit, raises a block-complete flag and, if that flag is enabled, an interrupt.

Register map (word offset on `regAddr`):
- 0: control
- 1: element-size parameter
- 2: elements per frame
- 3: frames per block
- 4: source start address
- 5: destination start address
- 6: source element index
- 7: source frame index
- 8: destination element index
- 9: destination frame index
- 10: interrupt enable
- 11: status
- 12: live source address
- 13: live destination address
- 14: live element counter
- 15: live frame counter

Offsets 12 to 15 are read-only.

Top module: `dma_chan`

## Requirements
- R1: After reset, all sixteen registers read 0, `memReq` is low and `irq` is low.
- R2: A transfer starts when the control register is written with bit 7 set while bit 7 is clear and the channel is idle. The first memory access is then a read at the source start address, with `memSize` equal to the parameter register bits [1:0]. Those bits hold log2 of the element byte count: 0 means byte, 1 means halfword, 2 or 3 means word.
- R3: Only one access is outstanding at a time. A request holds its address and direction until `memAck`. Each write follows a completed read and carries that read's data in its low element-size bytes.
- R4: A transfer makes exactly elements-per-frame times frames-per-block read/write pairs.
- R5: The source mode is control bits [13:12] and the destination mode is control bits [15:14]. The value 1 means post-increment. Any other value keeps that address constant.
- R6: A post-incremented address advances after each element. Inside a frame the step is element bytes plus element index minus 1. After the last element of a frame the step is element bytes plus frame index minus 1. Each index is the low 16 bits of its register, read as a signed number.
- R7: The live element counter (offset 14) counts the elements done in the current frame and returns to 0 at each frame end. The live frame counter (offset 15) counts the frames done. The live addresses (offsets 12 and 13) hold the next addresses to be used.
- R8: When the final element is written, control bit 7 clears and status bit 5 sets.
- R9: `irq` is high exactly while status bit 5 and interrupt-enable bit 5 are both set.
- R10: Writing status with bit 5 set clears the flag. Writing a 0 in bit 5 leaves the flag unchanged.
- R11: A zero element count or a zero frame count completes the transfer with no memory access and sets status bit 5.
- R12: Clearing control bit 7 during a transfer stops the engine after the outstanding access. No further request is made and the status flag is not set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 4 | Register word offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational from `regAddr`) |
| memReq | output | 1 | Memory access request, held until acknowledged |
| memWe | output | 1 | 1 = write access, 0 = read access |
| memAddr | output | ADDR_W | Byte address of the access |
| memSize | output | 2 | log2 of the access byte count |
| memWdata | output | 32 | Write data, element in the low bytes |
| memRdata | input | 32 | Read data, valid with `memAck` |
| memAck | input | 1 | Access complete |
| irq | output | 1 | Block-complete interrupt |

## Verification
The bound checker watches the memory handshake on every cycle. It checks that a request stays stable until it is acknowledged, that no write is issued without a completed read before it, and that a new request only follows a cycle in which the channel was enabled. It also checks that the completion flag only rises as the enable bit falls, and that the interrupt never fires without its enable. Byte-exact memory contents, the stride arithmetic with negative indices, the final live counter values, the zero-count case and the abort case can only be shown by the bench. It runs transfers against a reference copy of memory and reads back the registers at the end.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  localparam logic [3:0] REG_CTRL      = 4'd0;
  localparam logic [3:0] REG_PARAM     = 4'd1;
  localparam logic [3:0] REG_ELEMS     = 4'd2;
  localparam logic [3:0] REG_FRAMES    = 4'd3;
  localparam logic [3:0] REG_SRC       = 4'd4;
  localparam logic [3:0] REG_DST       = 4'd5;
  localparam logic [3:0] REG_SRC_EIDX  = 4'd6;
  localparam logic [3:0] REG_SRC_FIDX  = 4'd7;
  localparam logic [3:0] REG_DST_EIDX  = 4'd8;
  localparam logic [3:0] REG_DST_FIDX  = 4'd9;
  localparam logic [3:0] REG_IRQ_EN    = 4'd10;
  localparam logic [3:0] REG_STATUS    = 4'd11;
  localparam logic [3:0] REG_LIVE_SRC  = 4'd12;
  localparam logic [3:0] REG_LIVE_DST  = 4'd13;
  localparam logic [3:0] REG_LIVE_ELEM = 4'd14;
  localparam logic [3:0] REG_LIVE_FRM  = 4'd15;

  localparam int ENABLE_POS   = 7;
  localparam int SRC_MODE_LSB = 12;
  localparam int DST_MODE_LSB = 14;
  localparam int DONE_POS     = 5;

  localparam logic [1:0] MODE_POSTINC = 2'd1;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CHECK,
    ST_READ,
    ST_WRITE
  } chanState_t;

  typedef struct packed {
    logic capture;
    logic step;
    logic finish;
  } dpStrobe_t;

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int IDX_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [3:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              engineIdle,
  input  logic              finish,
  input  logic [ADDR_W-1:0] curSrc,
  input  logic [ADDR_W-1:0] curDst,
  input  logic [CNT_W-1:0]  curElem,
  input  logic [CNT_W-1:0]  curFrame,
  output logic              startPulse,
  output logic              enableBit,
  output logic [1:0]        srcMode,
  output logic [1:0]        dstMode,
  output logic [1:0]        sizeCode,
  output logic [CNT_W-1:0]  elemCnt,
  output logic [CNT_W-1:0]  frameCnt,
  output logic [ADDR_W-1:0] srcStart,
  output logic [ADDR_W-1:0] dstStart,
  output logic [IDX_W-1:0]  srcEIdx,
  output logic [IDX_W-1:0]  srcFIdx,
  output logic [IDX_W-1:0]  dstEIdx,
  output logic [IDX_W-1:0]  dstFIdx,
  output logic              irqEnBit,
  output logic              statusFlag,
  output logic              irq
);

  logic [31:0] ctrlReg;
  logic        wrCtrl;
  logic        wrStatus;

  assign wrCtrl     = regWe && (regAddr == REG_CTRL);
  assign wrStatus   = regWe && (regAddr == REG_STATUS);
  assign startPulse = wrCtrl && regWdata[ENABLE_POS] && !ctrlReg[ENABLE_POS] && engineIdle;

  assign enableBit = ctrlReg[ENABLE_POS];
  assign srcMode   = ctrlReg[SRC_MODE_LSB +: 2];
  assign dstMode   = ctrlReg[DST_MODE_LSB +: 2];
  assign irq       = statusFlag && irqEnBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg    <= '0;
      sizeCode   <= '0;
      elemCnt    <= '0;
      frameCnt   <= '0;
      srcStart   <= '0;
      dstStart   <= '0;
      srcEIdx    <= '0;
      srcFIdx    <= '0;
      dstEIdx    <= '0;
      dstFIdx    <= '0;
      irqEnBit   <= 1'b0;
      statusFlag <= 1'b0;
    end else begin
      if (wrCtrl) begin
        ctrlReg <= regWdata;
        ctrlReg[ENABLE_POS] <= startPulse || (regWdata[ENABLE_POS] && ctrlReg[ENABLE_POS]);
      end
      if (finish) ctrlReg[ENABLE_POS] <= 1'b0;

      if (regWe) begin
        case (regAddr)
          REG_PARAM:    sizeCode <= regWdata[1:0];
          REG_ELEMS:    elemCnt  <= regWdata[CNT_W-1:0];
          REG_FRAMES:   frameCnt <= regWdata[CNT_W-1:0];
          REG_SRC:      srcStart <= regWdata[ADDR_W-1:0];
          REG_DST:      dstStart <= regWdata[ADDR_W-1:0];
          REG_SRC_EIDX: srcEIdx  <= regWdata[IDX_W-1:0];
          REG_SRC_FIDX: srcFIdx  <= regWdata[IDX_W-1:0];
          REG_DST_EIDX: dstEIdx  <= regWdata[IDX_W-1:0];
          REG_DST_FIDX: dstFIdx  <= regWdata[IDX_W-1:0];
          REG_IRQ_EN:   irqEnBit <= regWdata[DONE_POS];
          default: ;
        endcase
      end

      if (finish) statusFlag <= 1'b1;
      else if (wrStatus && regWdata[DONE_POS]) statusFlag <= 1'b0;
    end
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      REG_CTRL:      regRdata = ctrlReg;
      REG_PARAM:     regRdata[1:0] = sizeCode;
      REG_ELEMS:     regRdata = 32'(elemCnt);
      REG_FRAMES:    regRdata = 32'(frameCnt);
      REG_SRC:       regRdata = 32'(srcStart);
      REG_DST:       regRdata = 32'(dstStart);
      REG_SRC_EIDX:  regRdata = 32'(srcEIdx);
      REG_SRC_FIDX:  regRdata = 32'(srcFIdx);
      REG_DST_EIDX:  regRdata = 32'(dstEIdx);
      REG_DST_FIDX:  regRdata = 32'(dstFIdx);
      REG_IRQ_EN:    regRdata[DONE_POS] = irqEnBit;
      REG_STATUS:    regRdata[DONE_POS] = statusFlag;
      REG_LIVE_SRC:  regRdata = 32'(curSrc);
      REG_LIVE_DST:  regRdata = 32'(curDst);
      REG_LIVE_ELEM: regRdata = 32'(curElem);
      REG_LIVE_FRM:  regRdata = 32'(curFrame);
      default:       regRdata = '0;
    endcase
  end

endmodule

// File: rtl/dma_chan_dp.sv
module dma_chan_dp
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int IDX_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  dpStrobe_t         strobe,
  input  logic [1:0]        srcMode,
  input  logic [1:0]        dstMode,
  input  logic [1:0]        sizeCode,
  input  logic [CNT_W-1:0]  elemCnt,
  input  logic [CNT_W-1:0]  frameCnt,
  input  logic [ADDR_W-1:0] srcStart,
  input  logic [ADDR_W-1:0] dstStart,
  input  logic [IDX_W-1:0]  srcEIdx,
  input  logic [IDX_W-1:0]  srcFIdx,
  input  logic [IDX_W-1:0]  dstEIdx,
  input  logic [IDX_W-1:0]  dstFIdx,
  input  logic [31:0]       memRdata,
  output logic [ADDR_W-1:0] curSrc,
  output logic [ADDR_W-1:0] curDst,
  output logic [CNT_W-1:0]  curElem,
  output logic [CNT_W-1:0]  curFrame,
  output logic [31:0]       dataHold,
  output logic              lastElem,
  output logic              zeroCount
);

  localparam int EXT_W = ADDR_W - IDX_W;

  logic [ADDR_W-1:0] elemBytes;
  logic              lastOfFrame;
  logic [ADDR_W-1:0] srcStep;
  logic [ADDR_W-1:0] dstStep;

  function automatic logic [ADDR_W-1:0] strideOf(input logic [1:0] mode,
                                                 input logic [IDX_W-1:0] idx,
                                                 input logic [ADDR_W-1:0] bytes);
    logic [ADDR_W-1:0] ext;
    ext = {{EXT_W{idx[IDX_W-1]}}, idx};
    if (mode == MODE_POSTINC) return bytes + ext - ADDR_W'(1);
    return '0;
  endfunction

  always_comb begin
    case (sizeCode)
      2'd0:    elemBytes = ADDR_W'(1);
      2'd1:    elemBytes = ADDR_W'(2);
      default: elemBytes = ADDR_W'(4);
    endcase
  end

  assign lastOfFrame = (curElem == elemCnt - CNT_W'(1));
  assign lastElem    = lastOfFrame && (curFrame == frameCnt - CNT_W'(1));
  assign zeroCount   = (elemCnt == '0) || (frameCnt == '0);

  assign srcStep = strideOf(srcMode, lastOfFrame ? srcFIdx : srcEIdx, elemBytes);
  assign dstStep = strideOf(dstMode, lastOfFrame ? dstFIdx : dstEIdx, elemBytes);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curSrc   <= '0;
      curDst   <= '0;
      curElem  <= '0;
      curFrame <= '0;
      dataHold <= '0;
    end else if (startPulse) begin
      curSrc   <= srcStart;
      curDst   <= dstStart;
      curElem  <= '0;
      curFrame <= '0;
    end else begin
      if (strobe.capture) dataHold <= memRdata;
      if (strobe.step) begin
        curSrc <= curSrc + srcStep;
        curDst <= curDst + dstStep;
        if (lastOfFrame) begin
          curElem  <= '0;
          curFrame <= curFrame + CNT_W'(1);
        end else begin
          curElem <= curElem + CNT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startPulse,
  input  logic      enableBit,
  input  logic      memAck,
  input  logic      zeroCount,
  input  logic      lastElem,
  output logic      memReq,
  output logic      memWe,
  output logic      engineIdle,
  output dpStrobe_t strobe
);

  chanState_t state;

  assign memReq     = (state == ST_READ) || (state == ST_WRITE);
  assign memWe      = (state == ST_WRITE);
  assign engineIdle = (state == ST_IDLE);

  always_comb begin
    strobe.capture = (state == ST_READ) && memAck;
    strobe.step    = (state == ST_WRITE) && memAck;
    strobe.finish  = ((state == ST_CHECK) && enableBit && zeroCount) ||
                     ((state == ST_WRITE) && memAck && lastElem && enableBit);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE:  if (startPulse) state <= ST_CHECK;
        ST_CHECK: state <= (!enableBit || zeroCount) ? ST_IDLE : ST_READ;
        ST_READ:  if (memAck) state <= enableBit ? ST_WRITE : ST_IDLE;
        ST_WRITE: if (memAck) state <= (lastElem || !enableBit) ? ST_IDLE : ST_READ;
        default:  state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int IDX_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [3:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [1:0]        memSize,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata,
  input  logic              memAck,
  output logic              irq
);

  dpStrobe_t         strobe;
  logic              startPulse, enableBit, engineIdle;
  logic              irqEnBit, statusFlag, lastElem, zeroCount;
  logic [1:0]        srcMode, dstMode, sizeCode;
  logic [CNT_W-1:0]  elemCnt, frameCnt, curElem, curFrame;
  logic [ADDR_W-1:0] srcStart, dstStart, curSrc, curDst;
  logic [IDX_W-1:0]  srcEIdx, srcFIdx, dstEIdx, dstFIdx;
  logic [31:0]       dataHold;

  assign memAddr  = memWe ? curDst : curSrc;
  assign memSize  = sizeCode;
  assign memWdata = dataHold;

  dma_chan_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .engineIdle(engineIdle), .finish(strobe.finish),
    .curSrc(curSrc), .curDst(curDst), .curElem(curElem), .curFrame(curFrame),
    .startPulse(startPulse), .enableBit(enableBit), .srcMode(srcMode), .dstMode(dstMode),
    .sizeCode(sizeCode), .elemCnt(elemCnt), .frameCnt(frameCnt),
    .srcStart(srcStart), .dstStart(dstStart), .srcEIdx(srcEIdx), .srcFIdx(srcFIdx),
    .dstEIdx(dstEIdx), .dstFIdx(dstFIdx), .irqEnBit(irqEnBit), .statusFlag(statusFlag),
    .irq(irq)
  );

  dma_chan_dp #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .strobe(strobe),
    .srcMode(srcMode), .dstMode(dstMode), .sizeCode(sizeCode),
    .elemCnt(elemCnt), .frameCnt(frameCnt), .srcStart(srcStart), .dstStart(dstStart),
    .srcEIdx(srcEIdx), .srcFIdx(srcFIdx), .dstEIdx(dstEIdx), .dstFIdx(dstFIdx),
    .memRdata(memRdata), .curSrc(curSrc), .curDst(curDst), .curElem(curElem),
    .curFrame(curFrame), .dataHold(dataHold), .lastElem(lastElem), .zeroCount(zeroCount)
  );

  dma_chan_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .enableBit(enableBit),
    .memAck(memAck), .zeroCount(zeroCount), .lastElem(lastElem),
    .memReq(memReq), .memWe(memWe), .engineIdle(engineIdle), .strobe(strobe)
  );

endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReq,
  input logic              memWe,
  input logic              memAck,
  input logic [ADDR_W-1:0] memAddr,
  input logic              enableBit,
  input logic              statusFlag,
  input logic              irqEnBit,
  input logic              irq
);

  logic readDone;

  always_ff @(posedge clk) begin
    if (!rstN) readDone <= 1'b0;
    else if (memReq && memAck) readDone <= !memWe;
  end

  // R3
  write_after_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |-> readDone);

  // R3
  request_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe)));

  // R2
  start_enabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memReq) |-> $past(enableBit));

  // R8
  done_clears_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusFlag) |-> !enableBit);

  // R9
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (irqEnBit && statusFlag));

endmodule

bind dma_chan dma_chan_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memWe(memWe), .memAck(memAck),
  .memAddr(memAddr), .enableBit(enableBit), .statusFlag(statusFlag),
  .irqEnBit(irqEnBit), .irq(irq)
);

// File: tb/dma_chan_bench.sv
module dma_chan_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [3:0]  regAddr = 4'd0;
  logic [31:0] regWdata = 32'd0;
  logic [31:0] regRdata;
  logic        memReq, memWe, irq;
  logic [31:0] memAddr, memWdata;
  logic [1:0]  memSize;
  logic [31:0] memRdata = 32'd0;
  logic        memAck = 1'b0;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [7:0]  mem  [0:4095];
  logic [7:0]  refm [0:4095];
  int          readCnt = 0;
  int          writeCnt = 0;
  logic [31:0] firstRdAddr = 32'd0;
  logic [1:0]  firstRdSize = 2'd0;
  logic [31:0] lastRd = 32'd0;
  bit          pendingRead = 1'b0;

  always #10 clk = ~clk;

  dma_chan u_dma_chan (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memSize(memSize), .memWdata(memWdata), .memRdata(memRdata), .memAck(memAck),
    .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] bytesOf(input logic [1:0] sz);
    return (sz == 2'd0) ? 32'd1 : (sz == 2'd1) ? 32'd2 : 32'd4;
  endfunction

  function automatic logic [31:0] strideOf(input logic [1:0] mode, input logic [15:0] idx, input logic [1:0] sz);
    if (mode != 2'd1) return 32'd0;
    return bytesOf(sz) + {{16{idx[15]}}, idx} - 32'd1;
  endfunction

  function automatic logic [31:0] laneMask(input logic [1:0] sz);
    return (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  // memory model with random response latency
  always @(posedge clk) begin
    logic [11:0] a;
    logic [31:0] rv;
    if (!rstN) begin
      memAck <= 1'b0;
    end else begin
      memAck <= 1'b0;
      if (memReq && !memAck && ($urandom_range(3) != 0)) begin
        memAck <= 1'b1;
        a = memAddr[11:0];
        if (!memWe) begin
          rv = {mem[a + 12'd3], mem[a + 12'd2], mem[a + 12'd1], mem[a]};
          memRdata <= rv;
          lastRd = rv;
          if (readCnt == 0) begin
            firstRdAddr = memAddr;
            firstRdSize = memSize;
          end
          readCnt++;
          pendingRead = 1'b1;
        end else begin
          // R3 write follows a read and carries its data
          chk(pendingRead, "R3 write without prior read", 32'(pendingRead), 32'd1);
          chk((memWdata & laneMask(memSize)) == (lastRd & laneMask(memSize)),
              "R3 write data", memWdata, lastRd);
          for (int b = 0; b < int'(bytesOf(memSize)); b++)
            mem[a + 12'(b)] = memWdata[8*b +: 8];
          writeCnt++;
          pendingRead = 1'b0;
        end
      end
    end
  end

  task automatic regWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRead(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  function automatic logic [31:0] ctrlWord(input logic [1:0] sm, input logic [1:0] dm, input bit en);
    return {16'd0, dm, sm, 4'd0, en, 7'd0};
  endfunction

  task automatic modelRun(input logic [1:0] sz, input logic [1:0] sm, input logic [1:0] dm,
                          input int ec, input int fc, input logic [31:0] sa, input logic [31:0] da,
                          input logic [15:0] sei, input logic [15:0] sfi,
                          input logic [15:0] dei, input logic [15:0] dfi,
                          output logic [31:0] fs, output logic [31:0] fd);
    logic [7:0] tmp [0:3];
    fs = sa; fd = da;
    if (ec == 0 || fc == 0) return;
    for (int f = 0; f < fc; f++) begin
      for (int e = 0; e < ec; e++) begin
        for (int b = 0; b < int'(bytesOf(sz)); b++) tmp[b] = refm[12'(fs[11:0] + 12'(b))];
        for (int b = 0; b < int'(bytesOf(sz)); b++) refm[12'(fd[11:0] + 12'(b))] = tmp[b];
        fs = fs + strideOf(sm, (e == ec - 1) ? sfi : sei, sz);
        fd = fd + strideOf(dm, (e == ec - 1) ? dfi : dei, sz);
      end
    end
  endtask

  task automatic waitDone(input string tag);
    logic [31:0] v;
    int n;
    n = 0;
    regRead(4'd0, v);
    while (v[7] && n < 20000) begin
      regRead(4'd0, v);
      n++;
    end
    chk(!v[7], {tag, " completion timeout"}, v, 32'd0);
  endtask

  task automatic runXfer(input logic [1:0] sz, input logic [1:0] sm, input logic [1:0] dm,
                         input int ec, input int fc, input logic [31:0] sa, input logic [31:0] da,
                         input logic [15:0] sei, input logic [15:0] sfi,
                         input logic [15:0] dei, input logic [15:0] dfi, input bit irqEn);
    logic [31:0] fs, fd, v;
    int mism;
    int total;
    total = ec * fc;
    for (int i = 0; i < 4096; i++) refm[i] = mem[i];
    modelRun(sz, sm, dm, ec, fc, sa, da, sei, sfi, dei, dfi, fs, fd);
    readCnt = 0; writeCnt = 0;
    regWrite(4'd1, 32'(sz));
    regWrite(4'd2, 32'(ec));
    regWrite(4'd3, 32'(fc));
    regWrite(4'd4, sa);
    regWrite(4'd5, da);
    regWrite(4'd6, 32'(sei));
    regWrite(4'd7, 32'(sfi));
    regWrite(4'd8, 32'(dei));
    regWrite(4'd9, 32'(dfi));
    regWrite(4'd10, irqEn ? 32'h20 : 32'h0);
    regWrite(4'd0, ctrlWord(sm, dm, 1'b1));
    waitDone("R8");
    mism = 0;
    for (int i = 0; i < 4096; i++) if (mem[i] !== refm[i]) mism++;
    // R5 R6 memory contents match the reference copy
    chk(mism == 0, "R5 R6 memory contents mismatched bytes", 32'(mism), 32'd0);
    // R4 access count
    chk(readCnt == total && writeCnt == total, "R4 access pairs", 32'(writeCnt), 32'(total));
    if (total == 0)
      chk(readCnt == 0, "R11 zero count makes no access", 32'(readCnt), 32'd0);
    else begin
      chk(firstRdAddr == sa, "R2 first read address", firstRdAddr, sa);
      chk(firstRdSize == sz, "R2 access size", 32'(firstRdSize), 32'(sz));
    end
    regRead(4'd11, v);
    chk(v[5], "R8 R11 status flag set", v, 32'h20);
    regRead(4'd12, v);
    chk(v == fs, "R6 R7 live source address", v, fs);
    regRead(4'd13, v);
    chk(v == fd, "R6 R7 live destination address", v, fd);
    if (total != 0) begin
      regRead(4'd14, v);
      chk(v == 32'd0, "R7 live element counter", v, 32'd0);
      regRead(4'd15, v);
      chk(v == 32'(fc), "R7 live frame counter", v, 32'(fc));
    end
    @(negedge clk);
    chk(irq == irqEn, "R9 irq level", 32'(irq), 32'(irqEn));
    regWrite(4'd11, 32'h0);
    regRead(4'd11, v);
    chk(v[5], "R10 status kept on zero write", v, 32'h20);
    regWrite(4'd11, 32'h20);
    regRead(4'd11, v);
    chk(v == 32'd0, "R10 status cleared", v, 32'd0);
    chk(irq == 1'b0, "R9 R10 irq low after clear", 32'(irq), 32'd0);
  endtask

  initial begin
    logic [31:0] v;
    int n;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4096; i++) mem[i] = 8'($urandom);
    repeat (3) @(posedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int r = 0; r < 16; r++) begin
      regRead(4'(r), v);
      chk(v == 32'd0, "R1 register reset value", v, 32'd0);
    end
    chk(memReq == 1'b0 && irq == 1'b0, "R1 outputs idle", {memReq, irq}, 32'd0);

    // directed cases
    runXfer(2'd2, 2'd0, 2'd1, 8, 1, 32'h100, 32'h800, 16'd1, 16'd1, 16'd1, 16'd1, 1'b1); // R5 constant source
    runXfer(2'd0, 2'd1, 2'd1, 5, 3, 32'h210, 32'h905, 16'd1, 16'd4, 16'd2, 16'hFFFE, 1'b1); // R6 byte strides
    runXfer(2'd1, 2'd1, 2'd0, 4, 2, 32'h302, 32'hA00, 16'hFFFD, 16'd7, 16'd1, 16'd1, 1'b0); // R5 const dest, R9 no irq
    runXfer(2'd3, 2'd3, 2'd2, 3, 2, 32'h400, 32'hB00, 16'd1, 16'd1, 16'd1, 16'd1, 1'b1); // R5 modes 3 and 2 constant
    runXfer(2'd2, 2'd1, 2'd1, 0, 3, 32'h500, 32'hC00, 16'd1, 16'd1, 16'd1, 16'd1, 1'b1); // R11 zero elements
    runXfer(2'd2, 2'd1, 2'd1, 4, 0, 32'h500, 32'hC00, 16'd1, 16'd1, 16'd1, 16'd1, 1'b0); // R11 zero frames

    // R12 abort mid-transfer
    readCnt = 0; writeCnt = 0;
    regWrite(4'd1, 32'd2);
    regWrite(4'd2, 32'd20);
    regWrite(4'd3, 32'd3);
    regWrite(4'd4, 32'h040);
    regWrite(4'd5, 32'hD00);
    regWrite(4'd0, ctrlWord(2'd1, 2'd1, 1'b1));
    n = 0;
    while (writeCnt < 3 && n < 2000) begin @(negedge clk); n++; end
    regWrite(4'd0, ctrlWord(2'd1, 2'd1, 1'b0));
    repeat (30) @(negedge clk);
    chk(memReq == 1'b0, "R12 no request after abort", 32'(memReq), 32'd0);
    chk(writeCnt < 60 && readCnt - writeCnt <= 1, "R12 transfer stopped early", 32'(writeCnt), 32'd60);
    regRead(4'd11, v);
    chk(v == 32'd0, "R12 status not set on abort", v, 32'd0);

    // constrained random transfers
    for (int t = 0; t < 30; t++) begin
      runXfer(2'($urandom_range(3)), 2'($urandom_range(3)), 2'($urandom_range(3)),
              int'($urandom_range(6)), int'($urandom_range(3)),
              $urandom, $urandom,
              16'($urandom_range(8)) - 16'd3, 16'($urandom_range(8)) - 16'd3,
              16'($urandom_range(8)) - 16'd3, 16'($urandom_range(8)) - 16'd3,
              1'($urandom_range(1)));
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule